// File: doc/BRIEF.md
# DVFS Operating-Point Sequencer

This block moves one clock/voltage domain from one operating point to another. A workload policy outside the block drives a required performance level. The block turns that level into a target by taking the slowest frequency entry whose performance rating meets it, and then the lowest voltage entry able to run that frequency. Both tables are elaboration-time parameters.

When the target frequency differs from the one in force, the block runs a two-step sequence. It drives a voltage index to an external regulator and a frequency index to an external clock generator. Between the steps it waits for the regulator's settled flag or the generator's lock flag. When the domain speeds up, the voltage moves first. When the domain slows down, the frequency moves first. A wait that runs past a programmable cycle limit is abandoned. In that case the old point is restored and a sticky fault is raised.

After reset the domain starts at its fastest table entry. Requests are taken only after both flags are high.

Top module: `dvfs_point_ctrl`

## Requirements
- R1: The target frequency index is the smallest index f whose performance rating PERF[f] is at least the requested level. The ratings rise strictly with the index. A level above every rating selects the highest index, NF-1.
- R2: The target voltage index is the smallest index v whose highest supported frequency index FMAX[v] is at least the target frequency. At every cycle, the driven voltage index supports the driven frequency index.
- R3: When the target frequency index is above the current one and the voltage index must change, only the voltage index changes at acceptance. The frequency index keeps its old value until the regulator handshake completes, and only then takes the new value.
- R4: When the target frequency index is below the current one, only the frequency index changes at acceptance. If the voltage index must also change, it is lowered only after the clock lock handshake completes.
- R5: A request is acted on only in idle, and only when its target frequency index differs from the current one. Otherwise busy stays low and both select outputs hold.
- R6: A change of request while a transition runs does not alter that transition. Once the transition ends, the request present at that time is served, and intermediate values are dropped.
- R7: A wait still incomplete after tmo_limit_i cycles aborts the transition. Both selects and the reported point return to the previous point, fault_o is set until reset, and the block goes idle. A limit of 0 disables the timeout.
- R8: busy_o rises in the cycle after a request is accepted. It falls in the cycle after the final handshake of the sequence. While busy_o is low, the reported current point equals the driven selects.
- R9: After reset, both selects show the highest frequency index and its lowest supporting voltage index. busy_o stays high until the settled flag and the lock flag are both high.
- R10: A handshake completes only when its flag is sampled low at some point after the select changed, and then sampled high.
- R11: After a timeout, a request whose target equals the failed frequency index is not retried. The block waits until some other transition completes.
- R12: A step whose voltage index would not change is skipped, and no regulator handshake is awaited for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perf_req_i | input | LVL_W | Required performance level from the workload policy |
| tmo_limit_i | input | TMO_W | Handshake wait limit in cycles, 0 = no limit |
| volt_sel_o | output | clog2(NV) | Voltage index to the regulator |
| freq_sel_o | output | clog2(NF) | Frequency index to the clock generator |
| volt_ok_i | input | 1 | Regulator output settled |
| clk_ok_i | input | 1 | Clock generator locked |
| busy_o | output | 1 | A boot wait or a transition is in progress |
| cur_volt_o | output | clog2(NV) | Voltage index of the last completed point |
| cur_freq_o | output | clog2(NF) | Frequency index of the last completed point |
| fault_o | output | 1 | Sticky handshake timeout flag |

## Verification
The bench sweeps every pair of request levels through the default tables. These pairs cover raises with and without a voltage step, falls with and without one, and saturation above the top rating. A design that swapped the step order would drive a frequency that the voltage present cannot support. A design that took a flag still high from an earlier change as completion would step on before the regulator or clock had reacted, so the models hold their flags high for a few cycles after a change.

Timeouts are checked for their exact abort cycle, for restoring the old point, and for not looping on the failed target. The bench also checks that a limit of zero waits indefinitely. A request changed in the middle of a transition must not redirect that transition. It must be served only afterwards.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_IDLE,
      ST_RISE_V,
      ST_RISE_F,
      ST_FALL_F,
      ST_FALL_V
   } op_state_e;

   // Handshake channel numbering used by the wait generate loop.
   localparam int CH_VOLT = 0;
   localparam int CH_CLK  = 1;

   // Lowest voltage entry whose frequency ceiling reaches f (8-bit fields).
   function automatic int min_volt_for(input logic [511:0] fmax_tbl, input int nv, input int f);
      int r;
      r = nv - 1;
      for (int v = nv - 1; v >= 0; v--) begin
         if (int'(fmax_tbl[v*8 +: 8]) >= f) r = v;
      end
      return r;
   endfunction

endpackage

// File: rtl/dvfs_point_pick.sv
module dvfs_point_pick #(
   parameter int NF = 4,
   parameter int NV = 4,
   parameter int LVL_W = 4,
   parameter int FI_W = 2,
   parameter int VI_W = 2,
   parameter logic [NF*LVL_W-1:0] FREQ_PERF = '0,
   parameter logic [NV*8-1:0] VOLT_FMAX = '0
) (
   input  logic [LVL_W-1:0] level_i,
   output logic [FI_W-1:0]  freq_o,
   output logic [VI_W-1:0]  volt_o
);

   // Elaboration-time sanity of the configuration.
   if (NF < 2 || NV < 2 || NV > 64) begin : g_bad_size
      $error("dvfs_point_pick: table sizes out of range");
   end
   for (genvar g = 1; g < NF; g++) begin : g_chk_perf
      if (FREQ_PERF[g*LVL_W +: LVL_W] <= FREQ_PERF[(g-1)*LVL_W +: LVL_W]) begin : g_bad
         $error("dvfs_point_pick: performance ratings must rise strictly");
      end
   end
   for (genvar g = 1; g < NV; g++) begin : g_chk_fmax
      if (VOLT_FMAX[g*8 +: 8] < VOLT_FMAX[(g-1)*8 +: 8]) begin : g_bad
         $error("dvfs_point_pick: voltage ceilings must not fall");
      end
   end
   if (int'(VOLT_FMAX[(NV-1)*8 +: 8]) < NF - 1) begin : g_bad_top
      $error("dvfs_point_pick: top voltage cannot run top frequency");
   end

   logic [NF-1:0] meets;

   for (genvar g = 0; g < NF; g++) begin : g_meet
      assign meets[g] = (FREQ_PERF[g*LVL_W +: LVL_W] >= level_i);
   end

   always_comb begin
      logic [FI_W-1:0] f;
      f = FI_W'(NF - 1);
      for (int i = NF - 1; i >= 0; i--) begin
         if (meets[i]) f = FI_W'(i);
      end
      freq_o = f;
      volt_o = VI_W'(dvfs_pkg::min_volt_for(512'(VOLT_FMAX), NV, int'(f)));
   end

endmodule

// File: rtl/dvfs_settle_wait.sv
module dvfs_settle_wait #(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             wait_i,
   input  logic             flag_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             done_o,
   output logic             expired_o
);

   logic             seen_low_q;
   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_low_q <= 1'b0;
         cnt_q      <= '0;
      end else if (arm_i) begin
         seen_low_q <= 1'b0;
         cnt_q      <= '0;
      end else if (wait_i) begin
         if (!flag_i) seen_low_q <= 1'b1;
         if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o    = wait_i && seen_low_q && flag_i;
   assign expired_o = wait_i && !done_o && (limit_i != '0) && (cnt_q == limit_i - 1'b1);

   // R10: a fresh wait cannot complete in the cycle right after it is armed.
   assert_arm_blocks_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> !done_o);

endmodule

// File: rtl/dvfs_point_ctrl.sv
module dvfs_point_ctrl #(
   parameter int NF = 4,
   parameter int NV = 4,
   parameter int LVL_W = 4,
   parameter int TMO_W = 8,
   parameter logic [NF*LVL_W-1:0] FREQ_PERF = {4'd14, 4'd9, 4'd5, 4'd2},
   parameter logic [NV*8-1:0] VOLT_FMAX = {8'd3, 8'd2, 8'd2, 8'd0}
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LVL_W-1:0]        perf_req_i,
   input  logic [TMO_W-1:0]        tmo_limit_i,
   output logic [$clog2(NV)-1:0]   volt_sel_o,
   output logic [$clog2(NF)-1:0]   freq_sel_o,
   input  logic                    volt_ok_i,
   input  logic                    clk_ok_i,
   output logic                    busy_o,
   output logic [$clog2(NV)-1:0]   cur_volt_o,
   output logic [$clog2(NF)-1:0]   cur_freq_o,
   output logic                    fault_o
);
   import dvfs_pkg::*;

   localparam int FI_W  = $clog2(NF);
   localparam int VI_W  = $clog2(NV);
   localparam int TOP_F = NF - 1;
   localparam int TOP_V = min_volt_for(512'(VOLT_FMAX), NV, TOP_F);

   logic [FI_W-1:0] pick_f;
   logic [VI_W-1:0] pick_v;

   dvfs_point_pick #(
      .NF(NF), .NV(NV), .LVL_W(LVL_W), .FI_W(FI_W), .VI_W(VI_W),
      .FREQ_PERF(FREQ_PERF), .VOLT_FMAX(VOLT_FMAX)
   ) u_pick (
      .level_i(perf_req_i),
      .freq_o (pick_f),
      .volt_o (pick_v)
   );

   op_state_e       st_q, st_d;
   logic [VI_W-1:0] vsel_q, vsel_d, curv_q, curv_d, tgtv_q, tgtv_d;
   logic [FI_W-1:0] fsel_q, fsel_d, curf_q, curf_d, tgtf_q, tgtf_d, failf_q, failf_d;
   logic            flt_q, flt_d, failv_q, failv_d;
   logic            finish, abort;

   // Handshake channels: index CH_VOLT follows the regulator, CH_CLK the clock.
   logic [1:0] ch_arm, ch_wait, ch_flag, ch_done, ch_exp;

   assign ch_flag[CH_VOLT] = volt_ok_i;
   assign ch_flag[CH_CLK]  = clk_ok_i;
   assign ch_wait[CH_VOLT] = (st_q == ST_RISE_V) || (st_q == ST_FALL_V);
   assign ch_wait[CH_CLK]  = (st_q == ST_RISE_F) || (st_q == ST_FALL_F);

   for (genvar c = 0; c < 2; c++) begin : g_wait
      dvfs_settle_wait #(.TMO_W(TMO_W)) u_wait (
         .clk      (clk),
         .rst_n    (rst_n),
         .arm_i    (ch_arm[c]),
         .wait_i   (ch_wait[c]),
         .flag_i   (ch_flag[c]),
         .limit_i  (tmo_limit_i),
         .done_o   (ch_done[c]),
         .expired_o(ch_exp[c])
      );
   end

   always_comb begin
      st_d    = st_q;
      vsel_d  = vsel_q;
      fsel_d  = fsel_q;
      curv_d  = curv_q;
      curf_d  = curf_q;
      tgtv_d  = tgtv_q;
      tgtf_d  = tgtf_q;
      flt_d   = flt_q;
      failv_d = failv_q;
      failf_d = failf_q;
      ch_arm  = 2'b00;
      finish  = 1'b0;
      abort   = 1'b0;
      case (st_q)
         ST_BOOT: begin
            if (volt_ok_i && clk_ok_i) st_d = ST_IDLE;
         end
         ST_IDLE: begin
            if (pick_f != curf_q && !(failv_q && pick_f == failf_q)) begin
               tgtf_d = pick_f;
               tgtv_d = pick_v;
               if (pick_f > curf_q) begin
                  if (pick_v != curv_q) begin
                     vsel_d = pick_v;
                     st_d   = ST_RISE_V;
                     ch_arm[CH_VOLT] = 1'b1;
                  end else begin
                     fsel_d = pick_f;
                     st_d   = ST_RISE_F;
                     ch_arm[CH_CLK] = 1'b1;
                  end
               end else begin
                  fsel_d = pick_f;
                  st_d   = ST_FALL_F;
                  ch_arm[CH_CLK] = 1'b1;
               end
            end
         end
         ST_RISE_V: begin
            if (ch_done[CH_VOLT]) begin
               fsel_d = tgtf_q;
               st_d   = ST_RISE_F;
               ch_arm[CH_CLK] = 1'b1;
            end else if (ch_exp[CH_VOLT]) begin
               abort = 1'b1;
            end
         end
         ST_RISE_F: begin
            if (ch_done[CH_CLK]) finish = 1'b1;
            else if (ch_exp[CH_CLK]) abort = 1'b1;
         end
         ST_FALL_F: begin
            if (ch_done[CH_CLK]) begin
               if (tgtv_q != curv_q) begin
                  vsel_d = tgtv_q;
                  st_d   = ST_FALL_V;
                  ch_arm[CH_VOLT] = 1'b1;
               end else begin
                  finish = 1'b1;
               end
            end else if (ch_exp[CH_CLK]) begin
               abort = 1'b1;
            end
         end
         ST_FALL_V: begin
            if (ch_done[CH_VOLT]) finish = 1'b1;
            else if (ch_exp[CH_VOLT]) abort = 1'b1;
         end
         default: st_d = ST_BOOT;
      endcase
      if (finish) begin
         curf_d  = tgtf_q;
         curv_d  = tgtv_q;
         failv_d = 1'b0;
         st_d    = ST_IDLE;
      end
      if (abort) begin
         vsel_d  = curv_q;
         fsel_d  = curf_q;
         flt_d   = 1'b1;
         failv_d = 1'b1;
         failf_d = tgtf_q;
         st_d    = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_BOOT;
         vsel_q  <= VI_W'(TOP_V);
         fsel_q  <= FI_W'(TOP_F);
         curv_q  <= VI_W'(TOP_V);
         curf_q  <= FI_W'(TOP_F);
         tgtv_q  <= VI_W'(TOP_V);
         tgtf_q  <= FI_W'(TOP_F);
         flt_q   <= 1'b0;
         failv_q <= 1'b0;
         failf_q <= '0;
      end else begin
         st_q    <= st_d;
         vsel_q  <= vsel_d;
         fsel_q  <= fsel_d;
         curv_q  <= curv_d;
         curf_q  <= curf_d;
         tgtv_q  <= tgtv_d;
         tgtf_q  <= tgtf_d;
         flt_q   <= flt_d;
         failv_q <= failv_d;
         failf_q <= failf_d;
      end
   end

   assign volt_sel_o = vsel_q;
   assign freq_sel_o = fsel_q;
   assign cur_volt_o = curv_q;
   assign cur_freq_o = curf_q;
   assign fault_o    = flt_q;
   assign busy_o     = (st_q != ST_IDLE);

   // R2: the driven voltage always covers the driven frequency.
   assert_volt_covers_freq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(VOLT_FMAX[int'(volt_sel_o)*8 +: 8]) >= int'(freq_sel_o));
   // R3: frequency holds while the raised voltage has not settled.
   assert_rise_holds_freq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RISE_V && !ch_done[CH_VOLT]) |=> $stable(freq_sel_o));
   // R4: voltage holds while the lowered clock has not locked.
   assert_fall_holds_volt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FALL_F && !ch_done[CH_CLK]) |=> $stable(volt_sel_o));
   // R5: a request naming the current frequency starts nothing.
   assert_same_point_stays_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && pick_f == cur_freq_o) |=> !busy_o);
   // R7: the fault flag is sticky, and an abort lands in idle.
   assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> fault_o);
   assert_abort_goes_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> !busy_o);
   // R8: when not busy, the reported point is the driven point.
   assert_idle_point_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (volt_sel_o == cur_volt_o && freq_sel_o == cur_freq_o));
   // R9: the boot wait drives the top frequency.
   assert_boot_top_freq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BOOT) |-> (int'(freq_sel_o) == TOP_F && busy_o));

endmodule

// File: tb/test_dvfs_point_ctrl.sv
module test_dvfs_point_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req = 4'd15;
   logic [7:0] tmo = 8'd60;
   logic [1:0] vsel, fsel, cur_v, cur_f;
   logic       v_ok, c_ok, busy, fault;

   int checks = 0;
   int errors = 0;

   // Model configuration, driven from the initial block.
   int v_dly = 3, c_dly = 5, v_lag = 0, c_lag = 0;
   bit v_stuck = 1'b0, c_stuck = 1'b0;

   // Tables matching the default parameters.
   int perf [4] = '{2, 5, 9, 14};
   int vmax [4] = '{0, 2, 2, 3};

   always #4 clk = ~clk;

   dvfs_point_ctrl i_dvfs_point_ctrl (
      .clk(clk), .rst_n(rst_n), .perf_req_i(req), .tmo_limit_i(tmo),
      .volt_sel_o(vsel), .freq_sel_o(fsel), .volt_ok_i(v_ok), .clk_ok_i(c_ok),
      .busy_o(busy), .cur_volt_o(cur_v), .cur_freq_o(cur_f), .fault_o(fault)
   );

   // Regulator model: drops settled after an optional lag, rises after a delay.
   logic [1:0] v_last; int v_cnt, v_lagc;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_ok <= 1'b0; v_last <= 2'd3; v_cnt <= v_dly; v_lagc <= 0;
      end else if (vsel != v_last) begin
         v_last <= vsel; v_lagc <= v_lag; v_cnt <= v_dly;
         if (v_lag == 0) v_ok <= 1'b0;
      end else if (v_lagc != 0) begin
         v_lagc <= v_lagc - 1;
         if (v_lagc == 1) v_ok <= 1'b0;
      end else if (!v_ok && !v_stuck) begin
         if (v_cnt == 0) v_ok <= 1'b1;
         else v_cnt <= v_cnt - 1;
      end
   end

   // Clock generator model, same shape.
   logic [1:0] c_last; int c_cnt, c_lagc;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_ok <= 1'b0; c_last <= 2'd3; c_cnt <= c_dly; c_lagc <= 0;
      end else if (fsel != c_last) begin
         c_last <= fsel; c_lagc <= c_lag; c_cnt <= c_dly;
         if (c_lag == 0) c_ok <= 1'b0;
      end else if (c_lagc != 0) begin
         c_lagc <= c_lagc - 1;
         if (c_lagc == 1) c_ok <= 1'b0;
      end else if (!c_ok && !c_stuck) begin
         if (c_cnt == 0) c_ok <= 1'b1;
         else c_cnt <= c_cnt - 1;
      end
   end

   function automatic int exp_f(input int lvl);
      int r;
      r = 3;
      for (int f = 3; f >= 0; f--) if (perf[f] >= lvl) r = f;
      return r;
   endfunction

   function automatic int exp_v(input int f);
      int r;
      r = 3;
      for (int v = 3; v >= 0; v--) if (vmax[v] >= f) r = v;
      return r;
   endfunction

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 600) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic move(input int lvl);
      int pf, pv, ef, ev, n;
      bit up, pv_ok, pc_ok, vs, cs, pvs, pcs;
      logic [1:0] lf, lv;
      pf = int'(fsel); pv = int'(vsel);
      ef = exp_f(lvl); ev = exp_v(ef);
      req = 4'(lvl);
      @(negedge clk);
      if (ef == pf) begin
         for (int k = 0; k < 3; k++) begin
            check(!busy && int'(fsel) == pf && int'(vsel) == pv,
                  "R5 same frequency starts no transition", int'(busy), 0);
            @(negedge clk);
         end
         return;
      end
      check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
      up = (ef > pf);
      if (up && ev != pv)
         check(int'(vsel) == ev && int'(fsel) == pf, "R3 voltage moves first on raise", int'(fsel), pf);
      else if (up)
         check(int'(fsel) == ef && int'(vsel) == pv, "R12 raise without voltage step", int'(vsel), pv);
      else
         check(int'(fsel) == ef && int'(vsel) == pv, "R4 frequency moves first on fall", int'(vsel), pv);
      vs = !v_ok; cs = !c_ok; lf = fsel; lv = vsel; n = 0;
      while (busy && n < 500) begin
         pv_ok = v_ok; pc_ok = c_ok; pvs = vs; pcs = cs;
         @(negedge clk);
         n++;
         if (fsel != lf)
            check(up && pv_ok && pvs, "R3 R10 frequency raised only after settle handshake", int'(pvs), 1);
         if (vsel != lv)
            check(!up && pc_ok && pcs, "R4 R10 voltage lowered only after lock handshake", int'(pcs), 1);
         if (!v_ok) vs = 1'b1;
         if (!c_ok) cs = 1'b1;
         lf = fsel; lv = vsel;
      end
      check(!busy, "R8 busy clears after final handshake", int'(busy), 0);
      check(int'(fsel) == ef, "R1 frequency choice", int'(fsel), ef);
      check(int'(vsel) == ev, "R2 voltage choice", int'(vsel), ev);
      check(int'(cur_f) == ef && int'(cur_v) == ev, "R8 reported point", int'(cur_f), ef);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      // R9: boot point and boot wait.
      c_stuck = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy && fsel == 2'd3 && vsel == 2'd3, "R9 boot drives top point", int'(fsel), 3);
      check(cur_f == 2'd3 && cur_v == 2'd3 && !fault, "R9 boot reported point", int'(cur_v), 3);
      repeat (30) @(negedge clk);
      check(busy == 1'b1, "R9 busy until lock seen", int'(busy), 1);
      c_stuck = 1'b0;
      wait_idle(n);
      check(!busy, "R9 idle once settled and locked", int'(busy), 0);

      // R1 R2 R3 R4 R5 R12: every pair of levels.
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            move(a);
            move(b);
         end
      end

      // R10: flags stay high for a while after a select change.
      v_lag = 3; c_lag = 3;
      move(0); move(15); move(7); move(0); move(12); move(4);
      v_lag = 0; c_lag = 0;
      repeat (10) @(negedge clk);

      // R6: request changes during a transition.
      move(0);
      req = 4'd15;
      @(negedge clk);
      repeat (2) @(negedge clk);
      req = 4'd6;
      @(negedge clk);
      req = 4'd4;
      wait_idle(n);
      check(fsel == 2'd3 && vsel == 2'd3, "R6 running transition not redirected", int'(fsel), 3);
      @(negedge clk);
      check(busy == 1'b1, "R6 newest request served next", int'(busy), 1);
      wait_idle(n);
      check(fsel == 2'd1 && vsel == 2'd1, "R6 newest request reached", int'(fsel), 1);

      // R7: limit 0 waits indefinitely.
      move(0);
      tmo = 8'd0;
      v_stuck = 1'b1;
      req = 4'd3;
      repeat (300) @(negedge clk);
      check(busy && !fault && fsel == 2'd0, "R7 zero limit never expires", int'(fault), 0);
      v_stuck = 1'b0;
      wait_idle(n);
      check(fsel == 2'd1 && vsel == 2'd1, "R7 zero limit completes later", int'(vsel), 1);

      // R7: expiry at the programmed cycle, restore, sticky fault.
      tmo = 8'd12;
      v_stuck = 1'b1;
      req = 4'd15;
      @(negedge clk);
      n = 0;
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
      check(n == 12, "R7 abort after limit cycles", n, 12);
      check(fault && !busy, "R7 fault raised and idle", int'(fault), 1);
      check(fsel == 2'd1 && vsel == 2'd1 && cur_f == 2'd1 && cur_v == 2'd1,
            "R7 previous point restored", int'(vsel), 1);
      // R11: the failed target is not retried.
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(!busy && fsel == 2'd1, "R11 failed target not retried", int'(busy), 0);
      end
      v_stuck = 1'b0;
      tmo = 8'd60;
      repeat (20) @(negedge clk);
      move(0);
      check(fault == 1'b1, "R7 fault stays set", int'(fault), 1);
      move(15);
      check(fault == 1'b1, "R7 fault stays after later success", int'(fault), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule